// File: doc/BRIEF.md
# Coprocessor Dual-Half Register File

This block is the register storage of an attached arithmetic coprocessor. It holds sixteen 64-bit registers, and each register can be reached as a whole or as a lower and an upper 32-bit half. Register indices come from a 32-bit instruction word that the block decodes itself. Two combinational read ports feed the coprocessor's operand paths, and a synchronous write port takes results back.

A host-side word port moves single 32-bit halves between the host and the register named by the first source field. A memory transfer port moves one or two 32-bit words per access, and a small sequencer steps through those words. Data sits in fixed halves: 32-bit integers in the lower half and single-precision values in the upper half. On two-word accesses a big-endian input, captured when the access starts, decides which half travels first.

The sequencer has three states. IDLE waits for a start. FIRST waits for the first data word. SECOND waits for the second word of a two-word access. The transitions are:
- LAUNCH: IDLE to FIRST, on a start with a valid kind.
- FINISH_ONE: FIRST to IDLE, when the only word of a one-word access is accepted.
- ADVANCE: FIRST to SECOND, when the first word of a two-word access is accepted.
- FINISH_TWO: SECOND to IDLE, when the second word is accepted.

Top module: `cp_dualhalf_regfile`

## Requirements
- R1: After reset every register reads as zero on all read paths.
- R2: The instruction word is decoded as follows: bits 15:12 are the destination index, bits 19:16 are source 1, and bits 3:0 are source 2. `opa_data` shows register[source 1] and `opb_data` shows register[source 2], each as {upper, lower}, combinationally.
- R3: When `wb_en` is high, `wb_data` is written to register[destination] at the next clock edge.
- R4: When `host_wr_en` is high, `host_wdata` is written to one half of register[source 1]: the upper half if `host_hi` is 1, the lower half if it is 0. The other half keeps its value.
- R5: `host_rdata` shows the half of register[source 1] selected by `host_hi` (1 = upper), combinationally.
- R6: Only one source writes in a cycle. A host write takes priority, and while it is present the memory port does not accept a word (`xfer_ready` is low). A memory load word takes priority over an ALU writeback. A writeback that loses arbitration is dropped.
- R7: A transfer starts only from IDLE, on `xfer_start`. The start captures the direction (`xfer_store`, 1 = store), the kind, the big-endian flag and the destination index. The kind codes are: 0 = one-word integer, 1 = one-word single, 2 = two-word, 3 = reserved. A reserved kind does not start a transfer, and a start during a transfer is ignored. `xfer_ready` is high only in FIRST and SECOND.
- R8: On a two-word transfer the first word goes to or comes from the upper half when the captured big-endian flag is 1, and the lower half when it is 0. The second word uses the other half.
- R9: A one-word integer load writes the data into the lower half and copies its bit 31 into every bit of the upper half.
- R10: A one-word single load writes only the upper half.
- R11: A one-word integer store reads the lower half and a one-word single store reads the upper half. Two-word stores follow R8. The data appears on `xfer_rdata` while `xfer_ready` is high.
- R12: `xfer_done` is high in the cycle the last word is accepted: the first word of a one-word transfer, or the second word of a two-word transfer. The sequencer is in IDLE on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn | input | 32 | Instruction word carrying the register index fields |
| opa_data | output | 64 | Operand A: register[source 1] |
| opb_data | output | 64 | Operand B: register[source 2] |
| wb_en | input | 1 | ALU writeback enable |
| wb_data | input | 64 | ALU writeback value |
| host_wr_en | input | 1 | Host half write enable |
| host_hi | input | 1 | Half select for host moves (1 = upper) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected half of register[source 1] |
| xfer_start | input | 1 | Start a memory transfer |
| xfer_store | input | 1 | Direction: 1 = store, 0 = load |
| xfer_kind | input | 2 | Transfer kind code |
| big_endian | input | 1 | Half order for two-word transfers |
| xfer_valid | input | 1 | A memory word is present this cycle |
| xfer_wdata | input | 32 | Load data word |
| xfer_rdata | output | 32 | Store data word |
| xfer_ready | output | 1 | The port accepts a word this cycle |
| xfer_done | output | 1 | The last word of the transfer is accepted |

## Verification
The assertions assume that the inputs follow the port protocol. A memory word counts only when `xfer_valid` and `xfer_ready` are both high. A write from any source has a defined address. The sequencer changes state only on an accepted word or a start from IDLE.

The stimulus drives every input at the falling edge. It raises `xfer_valid` only inside a transfer it has started. It never leaves the host or writeback enables high for more than the intended cycle. Randomized operations are mixed with directed collisions, such as a host write during a memory word and a start during a transfer, so the priority rules are exercised within this protocol.

// File: rtl/dhrf_pkg.sv
package dhrf_pkg;
    localparam int unsigned HALF_W     = 32;
    localparam int unsigned DST_LSB    = 12;
    localparam int unsigned SRC1_LSB   = 16;
    localparam int unsigned SRC2_LSB   = 0;

    typedef enum logic [1:0] {
        XK_INT32  = 2'd0,
        XK_SINGLE = 2'd1,
        XK_PAIR   = 2'd2,
        XK_RSVD   = 2'd3
    } xfer_kind_e;

    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_FIRST  = 2'd1,
        XS_SECOND = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/dhrf_field_dec.sv
module dhrf_field_dec #(
    parameter int unsigned IDX_W = 4
) (
    input  logic [31:0]      insn,
    output logic [IDX_W-1:0] dst_idx,
    output logic [IDX_W-1:0] src1_idx,
    output logic [IDX_W-1:0] src2_idx
);
    import dhrf_pkg::*;

    always_comb begin
        dst_idx  = insn[DST_LSB  +: IDX_W];
        src1_idx = insn[SRC1_LSB +: IDX_W];
        src2_idx = insn[SRC2_LSB +: IDX_W];
    end
endmodule

// File: rtl/dhrf_bank.sv
module dhrf_bank #(
    parameter int unsigned NREG   = 16,
    parameter int unsigned HALF_W = 32,
    localparam int unsigned IDX_W = $clog2(NREG),
    localparam int unsigned REG_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [HALF_W-1:0] wd_lo,
    input  logic [HALF_W-1:0] wd_hi,
    input  logic [IDX_W-1:0]  raddr_a,
    input  logic [IDX_W-1:0]  raddr_b,
    input  logic [IDX_W-1:0]  raddr_c,
    output logic [REG_W-1:0]  rd_a,
    output logic [REG_W-1:0]  rd_b,
    output logic [REG_W-1:0]  rd_c
);
    logic [HALF_W-1:0] lo_q [NREG];
    logic [HALF_W-1:0] hi_q [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[r] <= '0;
                hi_q[r] <= '0;
            end else begin
                if (we_lo && (waddr == IDX_W'(r))) lo_q[r] <= wd_lo;
                if (we_hi && (waddr == IDX_W'(r))) hi_q[r] <= wd_hi;
            end
        end
    end

    always_comb begin
        rd_a = {hi_q[raddr_a], lo_q[raddr_a]};
        rd_b = {hi_q[raddr_b], lo_q[raddr_b]};
        rd_c = {hi_q[raddr_c], lo_q[raddr_c]};
    end

    AST_LO_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we_lo |=> lo_q[$past(waddr)] == $past(wd_lo)); // R3
    AST_HI_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we_hi |=> hi_q[$past(waddr)] == $past(wd_hi)); // R4
endmodule

// File: rtl/dhrf_xfer_seq.sv
module dhrf_xfer_seq #(
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             store,
    input  logic [1:0]       kind,
    input  logic             be,
    input  logic [IDX_W-1:0] reg_in,
    input  logic             word_valid,
    input  logic             hold,
    output logic             ready,
    output logic             done,
    output logic             ld_lo,
    output logic             ld_hi,
    output logic             sext,
    output logic             sel_hi,
    output logic [IDX_W-1:0] reg_q
);
    import dhrf_pkg::*;

    xfer_state_e state_q, state_d;
    xfer_kind_e  kind_q;
    logic        store_q, be_q, cnt_q;
    logic        launch, accept, last, half_hi;

    assign launch = (state_q == XS_IDLE) && start && (xfer_kind_e'(kind) != XK_RSVD);

    always_comb begin
        ready   = (state_q != XS_IDLE) && !hold;
        accept  = ready && word_valid;
        unique case (kind_q)
            XK_INT32:  half_hi = 1'b0;
            XK_SINGLE: half_hi = 1'b1;
            default:   half_hi = cnt_q ? !be_q : be_q;
        endcase
        last    = (kind_q != XK_PAIR) || cnt_q;
        done    = accept && last;
        sext    = (kind_q == XK_INT32);
        ld_lo   = accept && !store_q && (!half_hi || sext);
        ld_hi   = accept && !store_q && (half_hi || sext);
        sel_hi  = half_hi;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:   if (launch) state_d = XS_FIRST;
            XS_FIRST:  if (accept) state_d = last ? XS_IDLE : XS_SECOND;
            XS_SECOND: if (accept) state_d = XS_IDLE;
            default:   state_d = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            kind_q  <= XK_INT32;
            store_q <= 1'b0;
            be_q    <= 1'b0;
            cnt_q   <= 1'b0;
            reg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                kind_q  <= xfer_kind_e'(kind);
                store_q <= store;
                be_q    <= be;
                reg_q   <= reg_in;
                cnt_q   <= 1'b0;
            end else if (accept && !last) begin
                cnt_q   <= 1'b1;
            end
        end
    end

    AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_IDLE) |-> !ready); // R7
    AST_SECOND_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_SECOND) |-> cnt_q); // R8
    AST_DONE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ready && word_valid)); // R12
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == XS_IDLE)); // R12
endmodule

// File: rtl/cp_dualhalf_regfile.sv
module cp_dualhalf_regfile #(
    parameter int unsigned NREG   = 16,
    parameter int unsigned HALF_W = 32,
    localparam int unsigned IDX_W = $clog2(NREG),
    localparam int unsigned REG_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       insn,
    output logic [REG_W-1:0]  opa_data,
    output logic [REG_W-1:0]  opb_data,
    input  logic              wb_en,
    input  logic [REG_W-1:0]  wb_data,
    input  logic              host_wr_en,
    input  logic              host_hi,
    input  logic [HALF_W-1:0] host_wdata,
    output logic [HALF_W-1:0] host_rdata,
    input  logic              xfer_start,
    input  logic              xfer_store,
    input  logic [1:0]        xfer_kind,
    input  logic              big_endian,
    input  logic              xfer_valid,
    input  logic [HALF_W-1:0] xfer_wdata,
    output logic [HALF_W-1:0] xfer_rdata,
    output logic              xfer_ready,
    output logic              xfer_done
);
    logic [IDX_W-1:0]  dst_idx, src1_idx, src2_idx, xreg;
    logic              ld_lo, ld_hi, sext, sel_hi;
    logic              we_lo, we_hi;
    logic [IDX_W-1:0]  waddr;
    logic [HALF_W-1:0] wd_lo, wd_hi;
    logic [REG_W-1:0]  rd_c;
    logic              unused_insn_bits;

    assign unused_insn_bits = ^{insn[31:20], insn[11:4]};

    dhrf_field_dec #(.IDX_W(IDX_W)) u_dec (
        .insn(insn), .dst_idx(dst_idx), .src1_idx(src1_idx), .src2_idx(src2_idx)
    );

    dhrf_xfer_seq #(.IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .store(xfer_store),
        .kind(xfer_kind), .be(big_endian), .reg_in(dst_idx),
        .word_valid(xfer_valid), .hold(host_wr_en), .ready(xfer_ready),
        .done(xfer_done), .ld_lo(ld_lo), .ld_hi(ld_hi), .sext(sext),
        .sel_hi(sel_hi), .reg_q(xreg)
    );

    always_comb begin
        we_lo = 1'b0;
        we_hi = 1'b0;
        waddr = dst_idx;
        wd_lo = wb_data[HALF_W-1:0];
        wd_hi = wb_data[REG_W-1:HALF_W];
        if (host_wr_en) begin
            waddr = src1_idx;
            we_lo = !host_hi;
            we_hi = host_hi;
            wd_lo = host_wdata;
            wd_hi = host_wdata;
        end else if (ld_lo || ld_hi) begin
            waddr = xreg;
            we_lo = ld_lo;
            we_hi = ld_hi;
            wd_lo = xfer_wdata;
            wd_hi = sext ? {HALF_W{xfer_wdata[HALF_W-1]}} : xfer_wdata;
        end else if (wb_en) begin
            we_lo = 1'b1;
            we_hi = 1'b1;
        end
    end

    dhrf_bank #(.NREG(NREG), .HALF_W(HALF_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we_lo(we_lo), .we_hi(we_hi), .waddr(waddr),
        .wd_lo(wd_lo), .wd_hi(wd_hi), .raddr_a(src1_idx), .raddr_b(src2_idx),
        .raddr_c(xreg), .rd_a(opa_data), .rd_b(opb_data), .rd_c(rd_c)
    );

    always_comb begin
        host_rdata = host_hi ? opa_data[REG_W-1:HALF_W] : opa_data[HALF_W-1:0];
        xfer_rdata = sel_hi ? rd_c[REG_W-1:HALF_W] : rd_c[HALF_W-1:0];
    end

    AST_HOST_BLOCKS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_en |-> !xfer_ready); // R6
    AST_HOST_OWNS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_en |-> ($onehot0({we_lo, we_hi}) && (waddr == src1_idx))); // R4
endmodule

// File: tb/sim_cp_dualhalf_regfile.sv
`timescale 1ns/1ps
module sim_cp_dualhalf_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] opa_data, opb_data;
    logic        wb_en = 1'b0;
    logic [63:0] wb_data = '0;
    logic        host_wr_en = 1'b0, host_hi = 1'b0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic        xfer_start = 1'b0, xfer_store = 1'b0, big_endian = 1'b0, xfer_valid = 1'b0;
    logic [1:0]  xfer_kind = '0;
    logic [31:0] xfer_wdata = '0, xfer_rdata;
    logic        xfer_ready, xfer_done;

    logic [63:0] model [16];
    int checks = 0, fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cp_dualhalf_regfile u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int d, input int s1, input int s2);
        logic [31:0] w;
        w = $urandom;
        w[19:16] = s1[3:0];
        w[15:12] = d[3:0];
        w[3:0]   = s2[3:0];
        return w;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_pair(input int a, input int b, input string req);
        insn = mk($urandom % 16, a, b);
        host_hi = 1'b0;
        #1;
        chk({req, " R2 opa"}, opa_data, model[a]);
        chk({req, " R2 opb"}, opb_data, model[b]);
        chk({req, " R5 host lo"}, {32'h0, host_rdata}, {32'h0, model[a][31:0]});
        host_hi = 1'b1;
        #1;
        chk({req, " R5 host hi"}, {32'h0, host_rdata}, {32'h0, model[a][63:32]});
    endtask

    task automatic host_write(input int idx, input bit hi, input logic [31:0] d);
        insn = mk($urandom % 16, idx, $urandom % 16);
        host_wr_en = 1'b1; host_hi = hi; host_wdata = d;
        tick();
        host_wr_en = 1'b0;
        if (hi) model[idx][63:32] = d; else model[idx][31:0] = d;
    endtask

    task automatic alu_write(input int idx, input logic [63:0] d);
        insn = mk(idx, $urandom % 16, $urandom % 16);
        wb_en = 1'b1; wb_data = d;
        tick();
        wb_en = 1'b0;
        model[idx] = d;
    endtask

    function automatic bit first_hi(input int kind, input bit be);
        if (kind == 0) return 1'b0;
        if (kind == 1) return 1'b1;
        return be;
    endfunction

    task automatic apply_load(input int idx, input int kind, input bit hi, input logic [31:0] d);
        if (kind == 0) model[idx] = {{32{d[31]}}, d};
        else if (hi) model[idx][63:32] = d;
        else model[idx][31:0] = d;
    endtask

    task automatic mem_xfer(input bit st, input int kind, input bit be, input int idx,
                            input logic [31:0] w0, input logic [31:0] w1, input bit gap);
        bit h0;
        h0 = first_hi(kind, be);
        insn = mk(idx, $urandom % 16, $urandom % 16);
        xfer_start = 1'b1; xfer_store = st; xfer_kind = kind[1:0]; big_endian = be;
        tick();
        xfer_start = 1'b0;
        big_endian = ~be;
        insn = mk((idx + 5) % 16, $urandom % 16, $urandom % 16);
        #1;
        chk("R7 ready after start", {63'h0, xfer_ready}, 64'h1);
        xfer_wdata = w0;
        xfer_valid = 1'b1;
        #1;
        if (st) chk(kind == 2 ? "R8 store first word" : "R11 store word",
                    {32'h0, xfer_rdata}, {32'h0, h0 ? model[idx][63:32] : model[idx][31:0]});
        chk("R12 done on first word", {63'h0, xfer_done}, {63'h0, kind != 2});
        tick();
        if (!st) apply_load(idx, kind, h0, w0);
        if (kind == 2) begin
            if (gap) begin
                xfer_valid = 1'b0;
                tick();
            end
            xfer_wdata = w1;
            xfer_valid = 1'b1;
            #1;
            if (st) chk("R8 store second word", {32'h0, xfer_rdata},
                        {32'h0, !h0 ? model[idx][63:32] : model[idx][31:0]});
            chk("R12 done on second word", {63'h0, xfer_done}, 64'h1);
            tick();
            if (!st) apply_load(idx, kind, !h0, w1);
        end
        xfer_valid = 1'b0;
        #1;
        chk("R12 idle after done", {63'h0, xfer_ready}, 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: all registers zero after reset
        for (int i = 0; i < 16; i++) check_pair(i, 15 - i, "R1 reset");
        #1;
        chk("R1 ready low after reset", {63'h0, xfer_ready}, 64'h0);

        // R3, R4: writeback then single-half host writes
        alu_write(4, 64'h0123_4567_89ab_cdef);
        check_pair(4, 0, "R3 writeback");
        host_write(4, 1'b0, 32'hdead_beef);
        check_pair(4, 4, "R4 host lo keeps hi");
        host_write(4, 1'b1, 32'hcafe_f00d);
        check_pair(4, 4, "R4 host hi keeps lo");

        // R6: host write and writeback in the same cycle; the writeback is dropped
        insn = mk(7, 8, 0);
        host_wr_en = 1'b1; host_hi = 1'b1; host_wdata = 32'h1111_2222;
        wb_en = 1'b1; wb_data = 64'hffff_ffff_ffff_ffff;
        tick();
        host_wr_en = 1'b0; wb_en = 1'b0;
        model[8][63:32] = 32'h1111_2222;
        check_pair(7, 8, "R6 host beats writeback");

        // R9: integer loads, negative and positive
        mem_xfer(1'b0, 0, 1'b0, 2, 32'h8000_0001, 32'h0, 1'b0);
        check_pair(2, 2, "R9 sign extend negative");
        mem_xfer(1'b0, 0, 1'b1, 3, 32'h7fff_0000, 32'h0, 1'b0);
        check_pair(3, 3, "R9 sign extend positive");
        // R10: single load writes only the upper half
        alu_write(5, 64'haaaa_aaaa_5555_5555);
        mem_xfer(1'b0, 1, 1'b0, 5, 32'h3f80_0000, 32'h0, 1'b0);
        check_pair(5, 5, "R10 single upper only");
        // R8: two-word loads in both orders, with a gap cycle
        mem_xfer(1'b0, 2, 1'b1, 6, 32'h0102_0304, 32'h0506_0708, 1'b1);
        check_pair(6, 6, "R8 big-endian load");
        mem_xfer(1'b0, 2, 1'b0, 9, 32'h0102_0304, 32'h0506_0708, 1'b0);
        check_pair(9, 9, "R8 little-endian load");
        // R11: stores of each kind
        mem_xfer(1'b1, 0, 1'b0, 4, 32'h0, 32'h0, 1'b0);
        mem_xfer(1'b1, 1, 1'b1, 4, 32'h0, 32'h0, 1'b0);
        mem_xfer(1'b1, 2, 1'b1, 6, 32'h0, 32'h0, 1'b0);
        mem_xfer(1'b1, 2, 1'b0, 6, 32'h0, 32'h0, 1'b1);

        // R7: reserved kind does not start
        insn = mk(1, 0, 0);
        xfer_start = 1'b1; xfer_kind = 2'd3; xfer_store = 1'b0;
        tick();
        xfer_start = 1'b0;
        #1;
        chk("R7 reserved kind ignored", {63'h0, xfer_ready}, 64'h0);

        // R6: host write holds off a memory word
        insn = mk(10, 0, 0);
        xfer_start = 1'b1; xfer_kind = 2'd2; xfer_store = 1'b0; big_endian = 1'b0;
        tick();
        xfer_start = 1'b0;
        insn = mk(0, 11, 0);
        host_wr_en = 1'b1; host_hi = 1'b0; host_wdata = 32'h7777_0000;
        xfer_valid = 1'b1; xfer_wdata = 32'h0000_aaaa;
        #1;
        chk("R6 host blocks ready", {63'h0, xfer_ready}, 64'h0);
        chk("R6 host blocks done", {63'h0, xfer_done}, 64'h0);
        tick();
        host_wr_en = 1'b0;
        model[11][31:0] = 32'h7777_0000;
        #1;
        chk("R6 ready after host", {63'h0, xfer_ready}, 64'h1);
        tick();
        model[10][31:0] = 32'h0000_aaaa;
        xfer_wdata = 32'h0000_bbbb;
        // R7: a start during a transfer is ignored
        xfer_start = 1'b1; xfer_kind = 2'd0; xfer_store = 1'b1;
        #1;
        chk("R12 done second word", {63'h0, xfer_done}, 64'h1);
        tick();
        model[10][63:32] = 32'h0000_bbbb;
        xfer_start = 1'b0; xfer_valid = 1'b0;
        #1;
        chk("R7 busy start ignored", {63'h0, xfer_ready}, 64'h0);
        check_pair(10, 11, "R6 held word lands");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op, idx, k;
            op = $urandom % 5;
            idx = $urandom % 16;
            k = $urandom % 3;
            case (op)
                0: host_write(idx, $urandom % 2, $urandom);
                1: alu_write(idx, {$urandom, $urandom});
                2: mem_xfer(1'b0, k, $urandom % 2, idx, $urandom, $urandom, $urandom % 2);
                3: mem_xfer(1'b1, k, $urandom % 2, idx, 32'h0, 32'h0, $urandom % 2);
                default: check_pair(idx, $urandom % 16, "R2 random");
            endcase
        end
        for (int i = 0; i < 16; i++) check_pair(i, (i + 3) % 16, "R3 final sweep");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule